// File: doc/BRIEF.md
# Watchdogged SPI Command Port with Fail-Mode Supervision

This block is the serial command port of a multi-channel output controller. A host sends 16-bit frames over a four-wire SPI link. Each frame carries a 4-bit register address, a watchdog toggle bit and 11 data bits. Frames of 32, 48 or more clocks are also accepted, so several devices can share one chip select in a daisy chain. The port turns each accepted frame into a one-cycle write strobe for the addressed register. At the same time it shifts out the reply that belongs to the previous frame.

The port also supervises its host. The host must flip the toggle bit on every write and must write often enough to restart a watchdog timer. Any of three causes pushes the device into fail mode and makes the input-side registers clear:

- a missed watchdog deadline,
- a frame whose clock count is not a multiple of 16,
- an external limp-home request.

The replies survive this. To leave fail mode, the limp request must be low and the host must send a two-frame handshake: first a frame with the toggle bit at 0, then one with the toggle bit at 1, inside one watchdog period. After that handshake every register clears and a sticky "registers were cleared" flag is raised. A read of the status register removes the flag.

All SPI pins are sampled by the system clock through two-stage synchronizers, so the SPI clock must stay well below the system clock; four system cycles per SPI clock phase is enough.

Top module: `wdspi_regif`

## Requirements
- R1: Frame bits [15:12] are the address, bit [11] is the watchdog toggle and bits [10:0] are data. An accepted frame raises `wr_stb[address]` for exactly one cycle, with `wr_data` equal to the data field; at most one strobe bit is high at a time.
- R2: While `spi_cs_n` is low, `spi_mosi` is taken MSB first on each rising `spi_sck`. While `spi_cs_n` is high, `spi_sck` and `spi_mosi` have no effect and `spi_miso_en` is low.
- R3: `spi_miso` shifts out, MSB first, the 16-bit reply captured at the end of the previous frame, and is valid before each rising `spi_sck`. Bits shifted in appear on `spi_miso` 16 clocks later. In a longer frame, the last 16 bits received form the command.
- R4: In normal mode, a frame whose toggle bit equals that of the last accepted write is ignored: no strobe fires and the watchdog is not restarted. After reset, the toggle value expected first is 0.
- R5: If no accepted write arrives within `WD_LIMIT` system clocks of the last restart, the watchdog error flag is set and fail mode is entered.
- R6: When `spi_cs_n` rises after a nonzero clock count that is not a multiple of 16, the framing error flag is set and fail mode is entered; the reply register is left unchanged. A chip-select pulse with no clocks has no effect.
- R7: A high `limp` enters fail mode. On entry, `clr_in` pulses for one cycle. While `fail_mode` is high, no write strobe fires.
- R8: The reply to address 1 is {4'h1, dsf, 7'b0, fail, wd_err, frm_err, rcf}. The reply to any other address is {address, dsf, `rd_data` at frame end}. dsf is rcf OR fail. Replies keep working in fail mode.
- R9: In fail mode with `limp` low, a frame with toggle 0 arms recovery. A frame with toggle 1 that follows it before `WD_LIMIT` clocks have passed then:
  - leaves fail mode,
  - clears both error flags,
  - pulses `clr_all`,
  - sets rcf,
  - loads the reply register with the status word.
- R10: The arming is dropped by a frame received while `limp` is high, by a framing error, or by a watchdog expiry. A toggle-1 frame that arrives while recovery is not armed has no effect.
- R11: An accepted write to address 1 clears rcf, and its own reply still shows the old rcf. When the recovery frame itself addresses register 1, rcf stays set.
- R12: `rst_n` low clears all flags and the reply register, and puts the port in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI clock |
| spi_mosi | input | 1 | SPI serial data in |
| spi_miso | output | 1 | SPI serial data out |
| spi_miso_en | output | 1 | Output enable for the serial data pad; low means high impedance |
| limp | input | 1 | Limp-home request, forces fail mode |
| rd_addr | output | 4 | Address field of the frame in the shifter, for the external read mux |
| rd_data | input | 11 | Read data of the register at `rd_addr` |
| wr_stb | output | 16 | One-hot write strobe per register address |
| wr_data | output | 11 | Data field of the accepted frame |
| clr_in | output | 1 | One-cycle pulse: clear input-side registers on fail entry |
| clr_all | output | 1 | One-cycle pulse: clear all registers on recovery |
| fail_mode | output | 1 | Fail mode active |

## Verification
Two collisions matter.

The first is recovery meeting read-clear. The frame that completes the recovery handshake is aimed at status register 1, so the event that sets rcf falls in the same cycle as an access that would otherwise clear it. The bench then reads the status word with the next frame and expects rcf and dsf to be 1.

The second is the watchdog timeout meeting the arming window. A toggle-0 frame arms recovery, the bench idles past `WD_LIMIT`, and then it sends a toggle-1 frame. That frame must not release fail mode, must not pulse `clr_all`, and the status reply afterwards must still show fail.

// File: rtl/wdspi_pkg.sv
package wdspi_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = FRAME_W - ADDR_W - 1;
  localparam int NREG    = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wd;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef struct packed {
    logic fail;
    logic wd_err;
    logic frm_err;
    logic rcf;
  } flags_t;

  // status reply: address, summary flag, padding, four flag bits
  function automatic logic [FRAME_W-1:0] status_word(flags_t f);
    status_word = {STAT_ADDR, f.rcf | f.fail, {(DATA_W-4){1'b0}},
                   f.fail, f.wd_err, f.frm_err, f.rcf};
  endfunction

  function automatic logic [FRAME_W-1:0] reply_word(logic [ADDR_W-1:0] a, flags_t f,
                                                    logic [DATA_W-1:0] rd);
    if (a == STAT_ADDR) reply_word = status_word(f);
    else                reply_word = {a, f.rcf | f.fail, rd};
  endfunction
endpackage

// File: rtl/wdspi_shifter.sv
module wdspi_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sck,
  input  logic               sdi,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sdo,
  output logic               sdo_en,
  output logic [FRAME_W-1:0] frame_word,
  output logic               frame_ok,
  output logic               frame_bad
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [1:0] cs_s, sck_s, si_s;
  logic       cs_prev, sck_prev, seen;
  logic [CNT_W-1:0]   bitcnt;
  logic [FRAME_W-1:0] sr;

  logic cs_q, active, cs_fall, cs_rise, sck_rise;
  assign cs_q     = cs_s[1];
  assign active   = !cs_q;
  assign cs_fall  = cs_prev && !cs_q;
  assign cs_rise  = !cs_prev && cs_q;
  assign sck_rise = active && sck_s[1] && !sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s     <= 2'b11;
      sck_s    <= 2'b00;
      si_s     <= 2'b00;
      cs_prev  <= 1'b1;
      sck_prev <= 1'b0;
    end else begin
      cs_s     <= {cs_s[0], cs_n};
      sck_s    <= {sck_s[0], sck};
      si_s     <= {si_s[0], sdi};
      cs_prev  <= cs_q;
      sck_prev <= sck_s[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      bitcnt    <= '0;
      seen      <= 1'b0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
    end else begin
      frame_ok  <= cs_rise && seen && (bitcnt == '0);
      frame_bad <= cs_rise && (bitcnt != '0);
      if (cs_fall) begin
        sr     <= load_word;
        bitcnt <= '0;
        seen   <= 1'b0;
      end else if (sck_rise) begin
        sr     <= {sr[FRAME_W-2:0], si_s[1]};
        bitcnt <= (bitcnt == CNT_W'(FRAME_W-1)) ? '0 : bitcnt + 1'b1;
        seen   <= 1'b1;
      end
    end
  end

  assign sdo        = sr[FRAME_W-1];
  assign sdo_en     = active;
  assign frame_word = sr;

  // R2: an idle select line leaves the shift register untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(sr));
endmodule

// File: rtl/wdspi_wdog.sv
module wdspi_wdog #(
  parameter int LIMIT = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (restart)             cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

  // R5: once expired, only a restart ends the timeout
  a_r5_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !restart |=> expired);
endmodule

// File: rtl/wdspi_mode.sv
module wdspi_mode
  import wdspi_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_word,
  input  logic               frame_ok,
  input  logic               frame_bad,
  input  logic               limp,
  input  logic               expired,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wd_restart,
  output logic [NREG-1:0]    wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic               clr_in,
  output logic               clr_all,
  output logic               fail_q,
  output logic [FRAME_W-1:0] rsp_q
);
  logic wd_err_q, frm_err_q, rcf_q, last_wd_q, armed_q;
  cmd_t   cmd;
  flags_t fl;
  assign cmd = cmd_t'(frame_word);
  assign fl  = flags_t'{fail: fail_q, wd_err: wd_err_q, frm_err: frm_err_q, rcf: rcf_q};

  logic toggled, enter_evt, accept, arm_evt, recover_evt;
  assign toggled     = (cmd.wd != last_wd_q);
  assign enter_evt   = !fail_q && (limp || frame_bad || expired);
  assign accept      = !fail_q && !enter_evt && frame_ok && toggled;
  assign arm_evt     = fail_q && frame_ok && !limp && !cmd.wd;
  assign recover_evt = fail_q && frame_ok && !limp && cmd.wd && armed_q && !expired;

  assign wd_restart = accept || arm_evt || recover_evt;
  assign clr_in     = enter_evt;
  assign clr_all    = recover_evt;
  assign wr_data    = cmd.data;

  for (genvar i = 0; i < NREG; i++) begin : g_stb
    assign wr_stb[i] = accept && (cmd.addr == ADDR_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q    <= 1'b0;
      wd_err_q  <= 1'b0;
      frm_err_q <= 1'b0;
      rcf_q     <= 1'b0;
      last_wd_q <= 1'b1;
      armed_q   <= 1'b0;
      rsp_q     <= '0;
    end else if (recover_evt) begin
      fail_q    <= 1'b0;
      wd_err_q  <= 1'b0;
      frm_err_q <= 1'b0;
      rcf_q     <= 1'b1;
      last_wd_q <= 1'b1;
      armed_q   <= 1'b0;
      rsp_q     <= status_word(flags_t'{fail: 1'b0, wd_err: 1'b0, frm_err: 1'b0, rcf: 1'b1});
    end else begin
      if (enter_evt)           fail_q    <= 1'b1;
      if (frame_bad)           frm_err_q <= 1'b1;
      if (!fail_q && expired)  wd_err_q  <= 1'b1;
      if (accept) begin
        last_wd_q <= cmd.wd;
        if (cmd.addr == STAT_ADDR) rcf_q <= 1'b0;
      end
      if (frame_ok) rsp_q <= reply_word(cmd.addr, fl, rd_data);
      if (arm_evt)  armed_q <= 1'b1;
      else if (frame_bad || (frame_ok && limp) || expired) armed_q <= 1'b0;
    end
  end

  // R10: arming only exists inside fail mode
  a_r10_arm_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> fail_q);
endmodule

// File: rtl/wdspi_regif.sv
module wdspi_regif
  import wdspi_pkg::*;
#(
  parameter int WD_LIMIT = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_en,
  input  logic              limp,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [NREG-1:0]   wr_stb,
  output logic [DATA_W-1:0] wr_data,
  output logic              clr_in,
  output logic              clr_all,
  output logic              fail_mode
);
  logic [FRAME_W-1:0] frame_word, rsp_q;
  logic frame_ok, frame_bad, wd_restart, wd_expired;

  wdspi_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .sdi(spi_mosi),
    .load_word(rsp_q), .sdo(spi_miso), .sdo_en(spi_miso_en),
    .frame_word(frame_word), .frame_ok(frame_ok), .frame_bad(frame_bad)
  );

  wdspi_wdog #(.LIMIT(WD_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .restart(wd_restart), .expired(wd_expired)
  );

  wdspi_mode u_mode (
    .clk(clk), .rst_n(rst_n), .frame_word(frame_word), .frame_ok(frame_ok),
    .frame_bad(frame_bad), .limp(limp), .expired(wd_expired), .rd_data(rd_data),
    .wd_restart(wd_restart), .wr_stb(wr_stb), .wr_data(wr_data),
    .clr_in(clr_in), .clr_all(clr_all), .fail_q(fail_mode), .rsp_q(rsp_q)
  );

  assign rd_addr = frame_word[FRAME_W-1 -: ADDR_W];

  // R1: never more than one register written per cycle
  a_r1_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));
  // R7: fail mode blocks every write
  a_r7_no_write_in_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail_mode |-> (wr_stb == '0));
  // R7: fail entry is always announced by the clear pulse
  a_r7_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_mode) |-> $past(clr_in));
  // R9: a recovery pulse is followed by normal mode
  a_r9_recover_exit: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> !fail_mode);
  // R2: a deselected port keeps its data pad released
  a_r2_pad_off: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) |-> !spi_miso_en);
endmodule

// File: tb/tb_wdspi_regif.sv
module tb_wdspi_regif;
  localparam int WDL = 3000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sck, mosi, miso, miso_en, limp, clr_in, clr_all, fail_mode;
  logic [3:0]  rd_addr;
  logic [10:0] rd_data, wr_data;
  logic [15:0] wr_stb;

  wdspi_regif #(.WD_LIMIT(WDL)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_en(miso_en), .limp(limp), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data), .clr_in(clr_in),
    .clr_all(clr_all), .fail_mode(fail_mode)
  );

  function automatic logic [10:0] rdfun(logic [3:0] a);
    return {a, 3'b101, ~a};
  endfunction
  assign rd_data = rdfun(rd_addr);

  int n_chk = 0, n_bad = 0, n_stb = 0, n_cin = 0, n_call = 0;
  logic [3:0]  stb_addr = '0;
  logic [10:0] stb_data = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (wr_stb != '0) begin
      n_stb++;
      for (int i = 0; i < 16; i++) if (wr_stb[i]) stb_addr = i[3:0];
      stb_data = wr_data;
    end
    if (clr_in)  n_cin++;
    if (clr_all) n_call++;
  end

  // bench model of the port state, built from the requirements
  logic m_fail, m_wd, m_frm, m_rcf, m_last, m_arm;
  logic [15:0] m_rsp;

  task automatic model_reset();
    m_fail = 0; m_wd = 0; m_frm = 0; m_rcf = 0; m_last = 1; m_arm = 0; m_rsp = '0;
  endtask

  function automatic logic [15:0] mresp(logic [3:0] a);
    logic dsf;
    dsf = m_rcf | m_fail;
    if (a == 4'd1) return {4'd1, dsf, 7'd0, m_fail, m_wd, m_frm, m_rcf};
    return {a, dsf, rdfun(a)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(int nb, logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = tx[i];
      repeat (3) @(posedge clk);
      @(negedge clk) rx = {rx[30:0], miso};
      @(posedge clk); #1 sck = 1'b1;
      repeat (4) @(posedge clk);
      #1 sck = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1 cs_n = 1'b1;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic settle(logic [3:0] a, logic w, logic [10:0] d, string tag, int s0, int c0);
    logic exp_s, rec;
    exp_s = 0; rec = 0;
    if (!m_fail) begin
      m_rsp = mresp(a);
      if (w != m_last) begin
        exp_s = 1; m_last = w;
        if (a == 4'd1) m_rcf = 0;
      end
    end else begin
      m_rsp = mresp(a);
      if (limp) m_arm = 0;
      else if (!w) m_arm = 1;
      else if (m_arm) begin
        rec = 1; m_fail = 0; m_wd = 0; m_frm = 0; m_rcf = 1; m_arm = 0; m_last = 1;
        m_rsp = 16'h1801;
      end
    end
    chk({tag, " strobe count"}, n_stb - s0, {31'd0, exp_s});
    if (exp_s) begin
      chk({tag, " strobe addr"}, {28'd0, stb_addr}, {28'd0, a});
      chk({tag, " strobe data"}, {21'd0, stb_data}, {21'd0, d});
    end
    chk({tag, " recovery pulse"}, n_call - c0, {31'd0, rec});
    chk({tag, " fail_mode"}, {31'd0, fail_mode}, {31'd0, m_fail});
  endtask

  task automatic frame(logic [3:0] a, logic w, logic [10:0] d, string tag);
    logic [31:0] rx;
    int s0, c0;
    s0 = n_stb; c0 = n_call;
    xfer(16, {16'd0, a, w, d}, rx);
    chk({tag, " reply (R3 R8)"}, {16'd0, rx[15:0]}, {16'd0, m_rsp});
    settle(a, w, d, tag, s0, c0);
  endtask

  task automatic badframe(int nb, string tag);
    logic [31:0] rx;
    int c0, s0;
    logic [15:0] keep;
    c0 = n_cin; s0 = n_stb; keep = m_rsp;
    xfer(nb, 32'h0000_6D5B, rx);
    if (nb > 0) chk({tag, " partial reply"}, rx, {16'd0, keep >> (16 - nb)});
    if (nb % 16 != 0) begin
      chk({tag, " entry pulse"}, n_cin - c0, m_fail ? 0 : 1);
      m_fail = 1; m_frm = 1; m_arm = 0;
    end else begin
      chk({tag, " no entry pulse"}, n_cin - c0, 0);
    end
    chk({tag, " no strobe"}, n_stb - s0, 0);
    chk({tag, " fail_mode"}, {31'd0, fail_mode}, {31'd0, m_fail});
  endtask

  task automatic set_limp(logic v, string tag);
    int c0;
    c0 = n_cin;
    @(posedge clk); #1 limp = v;
    repeat (4) @(posedge clk);
    #1;
    if (v && !m_fail) begin
      chk({tag, " entry pulse"}, n_cin - c0, 1);
      m_fail = 1; m_arm = 0;
    end else begin
      chk({tag, " no entry pulse"}, n_cin - c0, 0);
    end
    chk({tag, " fail_mode"}, {31'd0, fail_mode}, {31'd0, m_fail});
  endtask

  task automatic idle_out(string tag);
    int c0;
    c0 = n_cin;
    repeat (WDL + 50) @(posedge clk);
    #1;
    if (!m_fail) begin
      chk({tag, " timeout entry pulse"}, n_cin - c0, 1);
      m_fail = 1; m_wd = 1;
    end
    m_arm = 0;
    chk({tag, " fail_mode"}, {31'd0, fail_mode}, {31'd0, m_fail});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    int s0, c0;
    logic [3:0] a;
    logic w;
    logic [10:0] d;
    int unsigned seed_v;
    seed_v = $urandom(32'd9137);
    cs_n = 1; sck = 0; mosi = 0; limp = 0; rst_n = 0;
    model_reset();
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset pad enable", {31'd0, miso_en}, 0);
    chk("R12 reset fail_mode", {31'd0, fail_mode}, 0);
    chk("R12 reset strobes", {16'd0, wr_stb}, 0);

    frame(4'd3, 1'b0, 11'h155, "R1 R4 first write");
    frame(4'd4, 1'b0, 11'h0AA, "R4 repeated toggle ignored");
    frame(4'd1, 1'b1, 11'h7FF, "R8 status access");

    for (int i = 0; i < 24; i++) begin
      a = 4'($urandom % 16);
      w = ($urandom % 4 == 0) ? m_last : !m_last;
      d = 11'($urandom);
      frame(a, w, d, "R1 R4 random");
    end

    // R3 daisy chain: 32 clocks, last 16 bits are the command
    s0 = n_stb; c0 = n_call;
    xfer(32, {16'hC3A5, 4'd6, !m_last, 11'h2C7}, rx);
    chk("R3 daisy first half is reply", {16'd0, rx[31:16]}, {16'd0, m_rsp});
    chk("R3 daisy second half is passthrough", {16'd0, rx[15:0]}, 32'h0000_C3A5);
    settle(4'd6, !m_last, 11'h2C7, "R3 daisy command", s0, c0);

    badframe(0, "R6 empty select");
    frame(4'd1, !m_last, 11'h001, "R6 status after empty select");
    badframe(12, "R6 short frame");
    frame(4'd7, !m_last, 11'h3C3, "R7 R8 frame in fail");
    frame(4'd1, 1'b1, 11'h000, "R8 status in fail");
    frame(4'd2, 1'b0, 11'h000, "R9 arm");
    frame(4'd5, 1'b1, 11'h000, "R9 recover");
    frame(4'd1, 1'b0, 11'h000, "R9 R11 status read clears");
    frame(4'd1, 1'b1, 11'h000, "R11 reply before clear");
    frame(4'd6, 1'b0, 11'h000, "R11 flag now clear");

    set_limp(1'b1, "R7 limp entry");
    frame(4'd7, !m_last, 11'h111, "R7 no write under limp");
    frame(4'd0, 1'b0, 11'h000, "R10 arm under limp");
    frame(4'd0, 1'b1, 11'h000, "R10 no recover under limp");
    set_limp(1'b0, "R10 limp release");
    frame(4'd3, 1'b1, 11'h000, "R10 unarmed toggle one");
    frame(4'd3, 1'b0, 11'h000, "R10 arm");
    badframe(8, "R10 bad frame disarms");
    frame(4'd3, 1'b1, 11'h000, "R10 after disarm");
    frame(4'd2, 1'b0, 11'h000, "R11 arm");
    frame(4'd1, 1'b1, 11'h000, "R11 recover on status");
    frame(4'd9, 1'b0, 11'h0F0, "R11 flag kept after collision");

    idle_out("R5 watchdog");
    frame(4'd1, 1'b1, 11'h000, "R5 status shows timeout");
    frame(4'd4, 1'b0, 11'h000, "R9 arm before gap");
    idle_out("R9 window expires");
    frame(4'd4, 1'b1, 11'h000, "R9 late second command");
    frame(4'd4, 1'b0, 11'h000, "R9 rearm");
    frame(4'd8, 1'b1, 11'h000, "R9 timely recover");
    frame(4'd1, 1'b0, 11'h000, "R9 status after recover");

    @(posedge clk); #1 rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 fail cleared by reset", {31'd0, fail_mode}, 0);
    frame(4'd1, 1'b0, 11'h000, "R12 reply cleared");
    frame(4'd1, 1'b1, 11'h000, "R12 flags cleared");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule